// File: doc/BRIEF.md
# Bitplane Raster Pixel Formatter

This block sits at the end of a window layer's fetch pipeline. Each enabled clock it takes one 16-bit word read from video memory, a 24-bit layer configuration word and a 32-bit per-pixel command word. From these it produces the pixel for the current screen position. The configuration word sets the colour depth, the layer on/off switch, the direct-colour flag and two 8-bit colours. The command word gives the sub-pixel position within the fetched data, the window-visible flag and an 8-bit per-character colour.

The low two bits of the depth field always give the pixel packing within a byte: 8, 4, 2 or 1 pixels. This keeps the formatter in step with the address generator that steps the read pointer. A third depth bit selects the 16-bit source modes. In those modes per-cell colour comes either from the upper data byte or from the command word's character colour, and the all-ones code passes the full word through as direct colour.

The formatter is purely a datapath with one register stage, so it has no state machine. Its only sequencing is the clock enable, which either loads the next result or holds the current one.

Top module: `raster_bitplane_fmt`

## Requirements
- R1: While `rst_n` is low, `pix_out`, `vis_out` and `direct565_out` are all zero.
- R2: Field positions are fixed. In `cfg_word`, the mode byte is [7:0] (depth [2:0], layer on [3], direct-colour flag [4]), the background colour is [15:8] and the foreground colour is [23:16]. In `cmd_word`, the sub-pixel position is [4:0] (only [2:0] select within a byte), window visible is [7] and the character colour is [15:8].
- R3: If window visible is 0 or layer on is 0, then one clock later `pix_out` is 16'h0000 and `vis_out` is 0.
- R4: If both window visible and layer on are 1, then one clock later `vis_out` is 1. All outputs update on the clock edge where `clk_en` is high, with one cycle of latency.
- R5: While `clk_en` is low, all three outputs keep their values.
- R6: Depth 3'b000 (1 bit per pixel). Let b = mem_word[7 - x[2:0]]. The output is {8'h00, fg[7:4], char[7:4]} when b is 1 and {8'h00, bg[7:4], char[3:0]} when b is 0. For all depths except 3'b111, `pix_out[15:8]` is zero.
- R7: Depth 3'b001 (2 bits per pixel). With p = x[2:1], the field is mem_word[7-2p -: 2], and the output is {8'h00, bg[7:2], field}.
- R8: Depth 3'b010 (4 bits per pixel). The field is mem_word[7:4] when x[2] is 0 and mem_word[3:0] when x[2] is 1. The output is {8'h00, bg[7:4], field}.
- R9: Depth 3'b011 (8 bits per pixel). The output is {8'h00, mem_word[7:0]}.
- R10: Depth 3'b100 (attribute text). Let b = mem_word[7 - x[2:0]]. The output is {8'h00, fg[7:4], mem_word[15:12]} when b is 1 and {8'h00, bg[7:4], mem_word[11:8]} when b is 0.
- R11: Depth 3'b101 (attribute 2 bits per pixel). The field is chosen as in R7, and the output is {8'h00, char[7:2], field}.
- R12: Depth 3'b110 (attribute 4 bits per pixel). The field is chosen as in R8, and the output is {8'h00, char[7:4], field}.
- R13: Depth 3'b111 (direct colour). The output is mem_word[15:0] unchanged.
- R14: `direct565_out` is the registered copy of `cfg_word[4]`. It is updated on every enabled clock, whatever the visibility.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Pixel enable; high loads a new result |
| mem_word | input | 16 | Word fetched from video memory |
| cfg_word | input | 24 | Layer mode byte, background and foreground colours |
| cmd_word | input | 32 | Sub-pixel position, window visible, character colour |
| pix_out | output | 16 | Formatted pixel value |
| vis_out | output | 1 | Registered window visibility |
| direct565_out | output | 1 | Registered direct-colour flag |

## Verification
The embedded properties check several behaviours on every cycle. They confirm that a hidden layer or window gives a zero pixel one clock later, that a visible one raises the visibility output, and that a held enable freezes all outputs. They also check that the direct-colour flag tracks its mode bit, that direct and 8-bit depths copy the memory word, and that every other depth leaves the upper pixel byte clear. The bench's directed sweeps are the only place where the sub-pixel field selection is checked for each depth. That covers the bit, pair and nibble ordering, the foreground/background choice and where the colour bits come from in the attribute modes.

// File: rtl/raster_fmt_pkg.sv
package raster_fmt_pkg;

    localparam int MEM_W   = 16;
    localparam int PIX_W   = 16;
    localparam int CFG_W   = 24;
    localparam int CMD_W   = 32;
    localparam int COL_W   = 8;
    localparam int BYTE_W  = 8;
    localparam int N_DEPTH = 4;
    localparam int SUBX_W  = 3;

    typedef enum logic [2:0] {
        MD_1BPP      = 3'b000,
        MD_2BPP      = 3'b001,
        MD_4BPP      = 3'b010,
        MD_8BPP      = 3'b011,
        MD_ATTR_TEXT = 3'b100,
        MD_ATTR_2BPP = 3'b101,
        MD_ATTR_4BPP = 3'b110,
        MD_DIRECT    = 3'b111
    } depth_mode_e;

    typedef struct packed {
        logic [2:0]  spare;
        logic        direct565;
        logic        layer_on;
        depth_mode_e depth;
    } mode_byte_t;

    typedef struct packed {
        logic [COL_W-1:0] fg;
        logic [COL_W-1:0] bg;
        mode_byte_t       mode;
    } cfg_word_t;

    typedef struct packed {
        logic [15:0]      upper;
        logic [COL_W-1:0] char_col;
        logic             show;
        logic [1:0]       rsv;
        logic [4:0]       subx;
    } cmd_word_t;

endpackage

// File: rtl/raster_depth_select.sv
module raster_depth_select
    import raster_fmt_pkg::*;
(
    input  logic [BYTE_W-1:0]               byte_in,
    input  logic [SUBX_W-1:0]               sub_x,
    output logic [N_DEPTH-1:0][BYTE_W-1:0]  field_q
);

    // One extractor per packing: 1, 2, 4 or 8 bits per pixel.
    // Pixel 0 of a byte sits in the most significant field.
    for (genvar k = 0; k < N_DEPTH; k++) begin : g_depth
        localparam int BPP   = 1 << k;
        localparam int SLOTS = BYTE_W / BPP;
        localparam logic [BYTE_W-1:0] MASK = BYTE_W'((1 << BPP) - 1);

        logic [SUBX_W-1:0] slot;
        logic [3:0]        shamt;

        assign slot          = sub_x >> k;
        assign shamt         = 4'((SLOTS - 1 - int'(slot)) * BPP);
        assign field_q[k]    = (byte_in >> shamt) & MASK;
    end

endmodule

// File: rtl/raster_pixel_compose.sv
module raster_pixel_compose
    import raster_fmt_pkg::*;
(
    input  cfg_word_t                        cfg,
    input  cmd_word_t                        cmd,
    input  logic [MEM_W-1:0]                 mem_word,
    input  logic [N_DEPTH-1:0][BYTE_W-1:0]   field_q,
    output logic [PIX_W-1:0]                 pix_next,
    output logic                             vis_next
);

    localparam logic [7:0] ZB = 8'h00;

    logic             lit;
    logic [PIX_W-1:0] body;

    assign lit = field_q[0][0];

    always_comb begin
        body = '0;
        unique case (cfg.mode.depth)
            MD_1BPP:      body = {ZB, lit ? {cfg.fg[7:4], cmd.char_col[7:4]}
                                          : {cfg.bg[7:4], cmd.char_col[3:0]}};
            MD_2BPP:      body = {ZB, cfg.bg[7:2], field_q[1][1:0]};
            MD_4BPP:      body = {ZB, cfg.bg[7:4], field_q[2][3:0]};
            MD_8BPP:      body = {ZB, field_q[3]};
            MD_ATTR_TEXT: body = {ZB, lit ? {cfg.fg[7:4], mem_word[15:12]}
                                          : {cfg.bg[7:4], mem_word[11:8]}};
            MD_ATTR_2BPP: body = {ZB, cmd.char_col[7:2], field_q[1][1:0]};
            MD_ATTR_4BPP: body = {ZB, cmd.char_col[7:4], field_q[2][3:0]};
            MD_DIRECT:    body = mem_word;
            default:      body = '0;
        endcase
    end

    always_comb begin
        vis_next = cmd.show && cfg.mode.layer_on;
        pix_next = vis_next ? body : '0;
    end

endmodule

// File: rtl/raster_out_stage.sv
module raster_out_stage
    import raster_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [PIX_W-1:0] pix_next,
    input  logic             vis_next,
    input  logic             m565_next,
    output logic [PIX_W-1:0] pix_q,
    output logic             vis_q,
    output logic             m565_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q  <= '0;
            vis_q  <= 1'b0;
            m565_q <= 1'b0;
        end else if (clk_en) begin
            pix_q  <= pix_next;
            vis_q  <= vis_next;
            m565_q <= m565_next;
        end
    end

    // R5: a held enable freezes every output
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(pix_q) && $stable(vis_q) && $stable(m565_q)));

    // R1: reset clears the stage (checked while reset is held)
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (pix_q == '0 && !vis_q && !m565_q);
        end
    end

endmodule

// File: rtl/raster_bitplane_fmt.sv
module raster_bitplane_fmt
    import raster_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [15:0]      mem_word,
    input  logic [23:0]      cfg_word,
    input  logic [31:0]      cmd_word,
    output logic [15:0]      pix_out,
    output logic             vis_out,
    output logic             direct565_out
);

    cfg_word_t                       cfg;
    cmd_word_t                       cmd;
    logic [N_DEPTH-1:0][BYTE_W-1:0]  field_q;
    logic [PIX_W-1:0]                pix_next;
    logic                            vis_next;

    assign cfg = cfg_word_t'(cfg_word);
    assign cmd = cmd_word_t'(cmd_word);

    raster_depth_select u_sel (
        .byte_in (mem_word[BYTE_W-1:0]),
        .sub_x   (cmd.subx[SUBX_W-1:0]),
        .field_q (field_q)
    );

    raster_pixel_compose u_cmp (
        .cfg      (cfg),
        .cmd      (cmd),
        .mem_word (mem_word),
        .field_q  (field_q),
        .pix_next (pix_next),
        .vis_next (vis_next)
    );

    raster_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .pix_next  (pix_next),
        .vis_next  (vis_next),
        .m565_next (cfg.mode.direct565),
        .pix_q     (pix_out),
        .vis_q     (vis_out),
        .m565_q    (direct565_out)
    );

    // R3: hidden window or layer gives a blank pixel next clock
    p_off_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !(cmd_word[7] && cfg_word[3])) |=> (pix_out == 16'h0000 && !vis_out));

    // R4: visible window raises the visibility output next clock
    p_vis_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cmd_word[7] && cfg_word[3]) |=> vis_out);

    // R14: direct-colour flag follows its mode bit
    p_flag565_r14: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> (direct565_out == $past(cfg_word[4])));

    // R13: direct colour passes the word through
    p_direct_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cmd_word[7] && cfg_word[3] && cfg_word[2:0] == 3'b111)
            |=> (pix_out == $past(mem_word)));

    // R9: 8 bits per pixel copies the low byte
    p_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cmd_word[7] && cfg_word[3] && cfg_word[2:0] == 3'b011)
            |=> (pix_out == {8'h00, $past(mem_word[7:0])}));

    // R6: all palette depths leave the upper pixel byte clear
    p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cfg_word[2:0] != 3'b111) |=> (pix_out[15:8] == 8'h00));

endmodule

// File: tb/tb_raster_bitplane_fmt.sv
module tb_raster_bitplane_fmt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [15:0] mem_word = '0;
    logic [23:0] cfg_word = '0;
    logic [31:0] cmd_word = '0;
    logic [15:0] pix_out;
    logic        vis_out;
    logic        direct565_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    raster_bitplane_fmt dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .clk_en        (clk_en),
        .mem_word      (mem_word),
        .cfg_word      (cfg_word),
        .cmd_word      (cmd_word),
        .pix_out       (pix_out),
        .vis_out       (vis_out),
        .direct565_out (direct565_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic string mode_req(input logic [2:0] m);
        case (m)
            3'd0: return "R6";
            3'd1: return "R7";
            3'd2: return "R8";
            3'd3: return "R9";
            3'd4: return "R10";
            3'd5: return "R11";
            3'd6: return "R12";
            default: return "R13";
        endcase
    endfunction

    // Reference model built from the requirement text
    function automatic logic [15:0] model(input logic [2:0] m, input logic [7:0] fg,
                                          input logic [7:0] bg, input logic [7:0] chr,
                                          input logic [2:0] x, input logic [15:0] d);
        logic       b;
        logic [1:0] pr;
        logic [3:0] nb;
        b  = d[7 - x];
        pr = d[7 - 2*x[2:1] -: 2];
        nb = x[2] ? d[3:0] : d[7:4];
        case (m)
            3'd0: return b ? {8'h00, fg[7:4], chr[7:4]} : {8'h00, bg[7:4], chr[3:0]};
            3'd1: return {8'h00, bg[7:2], pr};
            3'd2: return {8'h00, bg[7:4], nb};
            3'd3: return {8'h00, d[7:0]};
            3'd4: return b ? {8'h00, fg[7:4], d[15:12]} : {8'h00, bg[7:4], d[11:8]};
            3'd5: return {8'h00, chr[7:2], pr};
            3'd6: return {8'h00, chr[7:4], nb};
            default: return d;
        endcase
    endfunction

    task automatic step(input logic en, input logic [23:0] c, input logic [31:0] k,
                        input logic [15:0] d);
        @(negedge clk);
        clk_en = en; cfg_word = c; cmd_word = k; mem_word = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        clk_en = 1'b1;
        cfg_word = 24'hFFFF1F;
        cmd_word = 32'h0000FF87;
        mem_word = 16'hFFFF;
        repeat (2) @(negedge clk);
        chk("R1 pix", {16'h0, pix_out}, 32'h0);
        chk("R1 vis", {31'h0, vis_out}, 32'h0);
        chk("R1 565", {31'h0, direct565_out}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_layer_off();
        step(1'b1, {8'h9E, 8'h41, 8'b000_0_0_011}, 32'h0000D780, 16'hA5C3);
        chk("R3 layer off pix", {16'h0, pix_out}, 32'h0);
        chk("R3 layer off vis", {31'h0, vis_out}, 32'h0);
        step(1'b1, {8'h9E, 8'h41, 8'b000_0_1_111}, 32'h0000D700, 16'hA5C3);
        chk("R3 window hidden pix", {16'h0, pix_out}, 32'h0);
        chk("R3 window hidden vis", {31'h0, vis_out}, 32'h0);
        step(1'b1, {8'h9E, 8'h41, 8'b000_0_1_111}, 32'h0000D780, 16'hA5C3);
        chk("R4 vis high", {31'h0, vis_out}, 32'h1);
        chk("R2 R13 direct", {16'h0, pix_out}, 32'h0000A5C3);
    endtask

    task automatic t_mode_sweep(input logic [2:0] m, input logic [15:0] d);
        logic [7:0] fg = 8'h9E;
        logic [7:0] bg = 8'h41;
        logic [7:0] chr = 8'hD7;
        for (int x = 0; x < 8; x++) begin
            logic [31:0] k;
            k = {16'hFFFF, chr, 1'b1, 2'b00, 2'b11, 3'(x)};
            step(1'b1, {fg, bg, 3'b000, 1'b0, 1'b1, m}, k, d);
            chk(mode_req(m), {16'h0, pix_out}, {16'h0, model(m, fg, bg, chr, 3'(x), d)});
            chk("R4 vis", {31'h0, vis_out}, 32'h1);
        end
    endtask

    task automatic t_hold();
        step(1'b1, {8'h9E, 8'h41, 8'b000_1_1_011}, 32'h0000D780, 16'h005A);
        chk("R9 load", {16'h0, pix_out}, 32'h0000005A);
        step(1'b0, {8'h9E, 8'h41, 8'b000_0_0_111}, 32'h00000000, 16'hFFFF);
        chk("R5 hold pix", {16'h0, pix_out}, 32'h0000005A);
        chk("R5 hold vis", {31'h0, vis_out}, 32'h1);
        chk("R5 hold 565", {31'h0, direct565_out}, 32'h1);
    endtask

    task automatic t_flag565();
        step(1'b1, {8'h00, 8'h00, 8'b000_1_0_000}, 32'h00000000, 16'h1234);
        chk("R14 set while hidden", {31'h0, direct565_out}, 32'h1);
        step(1'b1, {8'h00, 8'h00, 8'b000_0_1_111}, 32'h00000080, 16'h1234);
        chk("R14 clear", {31'h0, direct565_out}, 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_layer_off();
        for (int m = 0; m < 8; m++) begin
            t_mode_sweep(3'(m), 16'hA5C3);
            t_mode_sweep(3'(m), 16'h3C96);
        end
        t_hold();
        t_flag565();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule